// File: doc/BRIEF.md
# Oversampled Serial Receiver with Word Queue

This block turns an asynchronous serial line into data words. A one-cycle enable pulse at sixteen times the bit rate paces it. The line first passes through a synchronizer. A falling edge arms the receiver, and each bit of the frame is then decided by a two-of-three vote over the 7th, 8th and 9th ticks of that bit. The frame carries 7 or 8 data bits, least significant first. An optional extra bit may follow the data, and it is kept exactly as received, with no parity calculation. After that the first stop position is checked.

A word that ends in a valid stop bit is written into an 8-entry queue together with its extra bit. The consumer sees a ready flag and the oldest word and its extra bit at the outputs. It removes that entry with a pop strobe. A hold mode cuts the queue down to a single holding slot. A flush strobe empties the storage and clears the framing-error flag. A word that arrives when the storage is full wipes the whole storage.

The receive state machine has five states:
- IDLE: waits for a falling edge on the synchronized line.
- START: votes on the start bit. A vote of 1 is a glitch and returns to IDLE. A vote of 0 moves to DATA at the end of the bit period.
- DATA: shifts in bits. After the last data bit it moves to EXTRA when the extra bit is enabled, otherwise to STOP.
- EXTRA: captures the extra bit, then moves to STOP.
- STOP: votes at the 9th tick, either stores the word or flags a framing error, and returns to IDLE.

Top module: `serial_rx_queue`

## Requirements
- R1: A frame is armed only by a high-to-low change of the synchronized RX line while idle. If the start-bit vote gives 1, the receiver returns to idle and stores nothing.
- R2: Every bit takes the majority of the line values at the 7th, 8th and 9th ticks of its 16-tick period, so a wrong value at one of these samples does not change the result.
- R3: With `short_word_i` low, 8 data bits are received, least significant bit first, into `word_o[7:0]`. With it high, 7 bits are received and `word_o[7]` reads 0.
- R4: With `extra_en_i` high, one more bit after the data is stored unchanged and appears on `extra_o` with its word.
- R5: With `extra_en_i` low, the stored extra bit is 0.
- R6: A 0 at the first stop position sets `frame_err_o` and discards the word. The flag stays set through pops and clears when the next correctly framed word arrives.
- R7: While the storage is empty, `ready_o`, `word_o` and `extra_o` are all 0. This is also the state after reset.
- R8: Words leave in arrival order. A pop removes the oldest word, and a pop while empty has no effect.
- R9: A flush empties the storage and clears `frame_err_o`.
- R10: The queue holds 8 words. A word that arrives while 8 are held empties the queue, and the new word is not kept.
- R11: With `hold_mode_i` high the capacity is one word, and a second word that arrives while one is held empties the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| short_word_i | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| extra_en_i | input | 1 | 1 = one extra bit follows the data |
| hold_mode_i | input | 1 | 1 = single holding slot instead of the queue |
| pop_i | input | 1 | Remove the oldest word |
| flush_i | input | 1 | Empty storage and clear framing error |
| ready_o | output | 1 | Storage holds at least one word |
| word_o | output | 8 | Oldest word, zero when empty |
| extra_o | output | 1 | Extra bit of the oldest word, zero when empty |
| frame_err_o | output | 1 | Last frame had a bad stop bit |

## Verification
The bench uses the default parameters: 16 ticks per bit, 8-bit words, an 8-entry queue and two synchronizer stages. It delivers one tick every four clocks, so each bit lasts 64 clocks and a 4-clock pulse on the line corrupts exactly one tick sample. That makes it possible to test the single-sample tolerance of the vote directly. The 8-entry depth keeps the wipe-on-overflow case and the single-slot hold case within a few frames.

// File: rtl/srxq_pkg.sv
package srxq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_EXTRA = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/srxq_sync.sv
module srxq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srxq_deframer.sv
module srxq_deframer
    import srxq_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_s,
    input  logic              tick,
    input  logic              short_word,
    input  logic              extra_en,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    output logic              push_extra,
    output logic              frame_bad
);
    localparam int CW      = $clog2(OVS);
    localparam int BW      = $clog2(WORD_W);
    localparam int SAMP_A  = OVS / 2 - 2;   // 7th tick
    localparam int SAMP_B  = OVS / 2 - 1;   // 8th tick
    localparam int SAMP_C  = OVS / 2;       // 9th tick, vote point
    localparam int LAST_T  = OVS - 1;

    rx_state_t         state, nstate;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bit_idx;
    logic [BW-1:0]     last_idx;
    logic              vote_a, vote_b;
    logic              vote;
    logic              at_mid, at_end;
    logic              rx_prev;
    logic [WORD_W-1:0] shreg;
    logic              xbit;

    assign at_mid   = tick && (cnt == CW'(SAMP_C));
    assign at_end   = tick && (cnt == CW'(LAST_T));
    assign vote     = maj3(vote_a, vote_b, rx_s);
    assign last_idx = short_word ? BW'(WORD_W - 2) : BW'(WORD_W - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (rx_prev && !rx_s) nstate = ST_START;
            ST_START: begin
                if (at_mid && vote)  nstate = ST_IDLE;
                else if (at_end)     nstate = ST_DATA;
            end
            ST_DATA:  if (at_end && bit_idx == last_idx)
                          nstate = extra_en ? ST_EXTRA : ST_STOP;
            ST_EXTRA: if (at_end) nstate = ST_STOP;
            ST_STOP:  if (at_mid) nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // datapath: tick counter, votes, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_prev <= 1'b1;
            cnt     <= '0;
            vote_a  <= 1'b0;
            vote_b  <= 1'b0;
            bit_idx <= '0;
            shreg   <= '0;
            xbit    <= 1'b0;
        end else begin
            rx_prev <= rx_s;
            if (state == ST_IDLE)  cnt <= '0;
            else if (tick)         cnt <= at_end ? '0 : cnt + 1'b1;
            if (tick && cnt == CW'(SAMP_A)) vote_a <= rx_s;
            if (tick && cnt == CW'(SAMP_B)) vote_b <= rx_s;
            if (state == ST_IDLE) begin
                bit_idx <= '0;
                shreg   <= '0;
                xbit    <= 1'b0;
            end
            if (state == ST_DATA && at_mid) shreg[bit_idx] <= vote;
            if (state == ST_DATA && at_end) bit_idx <= bit_idx + 1'b1;
            if (state == ST_EXTRA && at_mid) xbit <= vote;
        end
    end

    // outputs
    always_comb begin
        push       = (state == ST_STOP) && at_mid && vote;
        frame_bad  = (state == ST_STOP) && at_mid && !vote;
        push_extra = xbit;
        push_data  = shreg;
        if (short_word) push_data[WORD_W-1] = 1'b0;
    end
endmodule

// File: rtl/srxq_store.sv
module srxq_store #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              push_extra,
    input  logic              pop,
    input  logic              flush,
    input  logic              hold_mode,
    output logic              ready,
    output logic [WORD_W-1:0] head_data,
    output logic              head_extra
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FW = $clog2(DEPTH + 1);

    logic [WORD_W:0] mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [FW-1:0]   fill, limit;
    logic            pop_ok, full, wipe;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign limit  = hold_mode ? FW'(1) : FW'(DEPTH);
    assign pop_ok = pop && (fill != '0);
    assign full   = fill >= limit;
    assign wipe   = flush || (push && full && !pop_ok);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else if (wipe) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push)   wr_ptr <= step(wr_ptr);
            if (pop_ok) rd_ptr <= step(rd_ptr);
            if (push && !pop_ok)      fill <= fill + 1'b1;
            else if (!push && pop_ok) fill <= fill - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !wipe) mem[wr_ptr] <= {push_extra, push_data};
    end

    assign ready = (fill != '0);
    always_comb begin
        if (ready) {head_extra, head_data} = mem[rd_ptr];
        else       {head_extra, head_data} = '0;
    end
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
    parameter int OVS         = 16,
    parameter int WORD_W      = 8,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              tick_i,
    input  logic              short_word_i,
    input  logic              extra_en_i,
    input  logic              hold_mode_i,
    input  logic              pop_i,
    input  logic              flush_i,
    output logic              ready_o,
    output logic [WORD_W-1:0] word_o,
    output logic              extra_o,
    output logic              frame_err_o
);
    logic              rx_s;
    logic              push, frame_bad, push_extra;
    logic [WORD_W-1:0] push_data;

    srxq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_i), .q(rx_s)
    );

    srxq_deframer #(.OVS(OVS), .WORD_W(WORD_W)) u_deframer (
        .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .tick(tick_i),
        .short_word(short_word_i), .extra_en(extra_en_i),
        .push(push), .push_data(push_data), .push_extra(push_extra),
        .frame_bad(frame_bad)
    );

    srxq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .push_extra(push_extra), .pop(pop_i), .flush(flush_i),
        .hold_mode(hold_mode_i), .ready(ready_o), .head_data(word_o),
        .head_extra(extra_o)
    );

    // framing-error flag: flush wins, a good frame clears, a bad one sets
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               frame_err_o <= 1'b0;
        else if (flush_i || push) frame_err_o <= 1'b0;
        else if (frame_bad)       frame_err_o <= 1'b1;
    end
endmodule

// File: rtl/srxq_checker.sv
module srxq_checker #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic              short_word_i,
    input logic              extra_en_i,
    input logic              ready_o,
    input logic [WORD_W-1:0] word_o,
    input logic              extra_o,
    input logic              frame_err_o
);
    assert_empty_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (word_o == '0 && !extra_o));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!ready_o && !frame_err_o));

    assert_extra_zero_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready_o) && !$past(extra_en_i)) |-> !extra_o);

    assert_short_msb_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready_o) && $past(short_word_i)) |-> !word_o[WORD_W-1]);
endmodule

bind serial_rx_queue srxq_checker #(.WORD_W(WORD_W)) u_srxq_checker (.*);

// File: tb/test_serial_rx_queue.sv
`timescale 1ns/1ps
module test_serial_rx_queue;
    localparam int W      = 8;
    localparam int D      = 8;
    localparam int TDIV   = 4;
    localparam int BITCLK = 16 * TDIV;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, rx, tick, short_w, xen, hold, pop, flush;
    logic ready, extra, ferr;
    logic [W-1:0] word;

    serial_rx_queue i_serial_rx_queue (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick),
        .short_word_i(short_w), .extra_en_i(xen), .hold_mode_i(hold),
        .pop_i(pop), .flush_i(flush), .ready_o(ready), .word_o(word),
        .extra_o(extra), .frame_err_o(ferr)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    logic [W:0] mq[$];
    logic m_ferr = 1'b0;

    initial begin
        tick = 1'b0;
        forever begin
            repeat (TDIV - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic chk(input string tag);
        logic er, ex;
        logic [W-1:0] ew;
        er = (mq.size() != 0);
        ew = er ? mq[0][W-1:0] : '0;
        ex = er ? mq[0][W] : 1'b0;
        checks++;
        if (ready !== er || word !== ew || extra !== ex || ferr !== m_ferr) begin
            errors++;
            $display("FAIL %s: ready=%0b word=%02h extra=%0b ferr=%0b expected ready=%0b word=%02h extra=%0b ferr=%0b",
                     tag, ready, word, extra, ferr, er, ew, ex, m_ferr);
        end
    endtask

    task automatic drive_bit(input logic b, input bit noisy);
        rx = b;
        if (noisy) begin
            repeat (31) @(negedge clk);
            rx = ~b;
            repeat (4) @(negedge clk);
            rx = b;
            repeat (BITCLK - 35) @(negedge clk);
        end else begin
            repeat (BITCLK) @(negedge clk);
        end
    endtask

    task automatic send(input logic [W-1:0] d, input bit sh, input bit xe,
                        input bit xb, input bit stop_ok, input bit noisy, input bit hm);
        logic [W-1:0] w;
        @(negedge clk);
        short_w = sh; xen = xe; hold = hm;
        drive_bit(1'b0, noisy);
        for (int i = 0; i < (sh ? W - 1 : W); i++) drive_bit(d[i], noisy);
        if (xe) drive_bit(xb, noisy);
        drive_bit(stop_ok, 1'b0);
        rx = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        if (stop_ok) begin
            m_ferr = 1'b0;
            w = d;
            if (sh) w[W-1] = 1'b0;
            if (mq.size() >= (hm ? 1 : D)) mq.delete();
            else mq.push_back({xe ? xb : 1'b0, w});
        end else begin
            m_ferr = 1'b1;
        end
    endtask

    task automatic do_pop();
        @(negedge clk); pop = 1'b1;
        @(negedge clk); pop = 1'b0;
        if (mq.size() != 0) void'(mq.pop_front());
        @(negedge clk);
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        mq.delete();
        m_ferr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        rst_n = 1'b0; rx = 1'b1; pop = 1'b0; flush = 1'b0;
        short_w = 1'b0; xen = 1'b0; hold = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 reset state");

        send(8'hA5, 0, 0, 0, 1, 0, 0); chk("R3 8-bit word");
        send(8'hFF, 1, 1, 1, 1, 0, 0); chk("R8 head unchanged by second word");
        do_pop();                      chk("R3 R4 7-bit word with extra bit");

        @(negedge clk); rx = 1'b0;
        repeat (8) @(negedge clk); rx = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        chk("R1 start glitch stores nothing");

        do_pop(); chk("R7 empty after last pop");
        do_pop(); chk("R8 pop on empty has no effect");

        send(8'h3C, 0, 1, 0, 1, 1, 0); chk("R2 vote with one bad sample");
        send(8'h81, 0, 0, 1, 1, 1, 0);
        do_pop(); chk("R5 extra bit zero when disabled");
        do_pop();

        send(8'h55, 0, 0, 0, 0, 0, 0); chk("R6 framing error set");
        send(8'h12, 0, 0, 0, 1, 0, 0);
        send(8'h66, 0, 0, 0, 0, 0, 0);
        do_pop(); chk("R6 pop keeps framing error");
        send(8'h34, 1, 0, 0, 1, 0, 0); chk("R6 good frame clears error");

        send(8'h77, 0, 0, 0, 0, 0, 0);
        do_flush(); chk("R9 flush clears storage and error");

        for (int i = 0; i < D; i++) send(8'(i * 17 + 3), 0, 1, i[0], 1, 0, 0);
        chk("R10 queue full");
        do_pop(); chk("R8 order after pop");
        send(8'hC3, 0, 0, 0, 1, 0, 0); chk("R10 refill to full");
        send(8'hE7, 0, 0, 0, 1, 0, 0); chk("R10 overflow empties queue");

        send(8'h5A, 0, 0, 0, 1, 0, 1); chk("R11 hold slot keeps one word");
        send(8'hA6, 0, 0, 0, 1, 0, 1); chk("R11 second word empties slot");
        send(8'h0F, 1, 1, 1, 1, 0, 1); chk("R11 slot refilled");
        do_pop();

        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] d;
            bit sh, xe, xb, ok, nz, hm;
            d  = 8'($urandom);
            sh = ($urandom % 2) == 1;
            xe = ($urandom % 2) == 1;
            xb = ($urandom % 2) == 1;
            ok = ($urandom % 10) != 0;
            nz = ($urandom % 4) == 0;
            hm = ($urandom % 8) == 0;
            send(d, sh, xe, xb, ok, nz, hm);
            chk("R2 R3 R4 R6 random frame");
            for (int p = 0; p < int'($urandom % 3); p++) begin
                do_pop();
                chk("R8 random pop");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule